// File: doc/BRIEF.md
# Serial Flash Command Controller

This block is the command front end of a serially attached NOR flash model. It oversamples the chip select, serial clock and serial data input with the system clock. It assembles each framed transfer into an opcode, an address and trailing bytes. When chip select is released, it decides whether the instruction is carried out. It holds the write-enable latch and the sleep (deep power-down) state. It also owns a countdown timer that stands in for the array while a program, erase or status-write cycle runs.

Accepted write-class instructions appear as a one-cycle pulse. The pulse carries a kind code and an argument for the array model. Read instructions raise a separate start pulse with the 24-bit address as soon as the address is complete, so that a read data path can begin streaming. A protection block can watch the same pulses. A status byte exposes the busy flag and the write-enable latch.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: A write-class instruction is discarded when the write-enable latch is clear. The write-class opcodes are 01h status write, 02h and A2h program, 42h one-time-area program, E5h lock write, 20h 4 KB erase, D8h 64 KB erase and C7h full erase.
- R2: A write-class instruction is accepted only when chip select rises after a whole number of bytes and the byte count matches the instruction. Status write takes 2 bytes, lock write 5 bytes, both erases of part of the array 4 bytes, and full erase 1 byte. The program instructions take 5 or more bytes. Any other frame changes nothing.
- R3: While the busy flag is set, every instruction is ignored, including latch set and clear, sleep and read. The running cycle continues.
- R4: The busy flag (status_o bit 0) rises in the cycle after the clock edge that first samples chip select high. It stays high for the configured number of cycles: T_STAT for status write, T_PROG for the three program instructions and lock write, T_SUB for 4 KB erase, T_SEC for 64 KB erase and T_BULK for full erase.
- R5: The write-enable latch clears in the same cycle that the busy flag of an accepted cycle falls.
- R6: A one-byte 06h frame sets the write-enable latch (status_o bit 1). A one-byte 04h frame clears it. Frames of any other length leave it unchanged.
- R7: A one-byte B9h frame enters sleep (sleep_o = 1). In sleep, every frame except a one-byte ABh frame is ignored, and ABh leaves sleep.
- R8: For a 03h or 0Bh frame, rd_start_o pulses for one cycle once 32 bits have been received, with rd_addr_o holding the three address bytes, most significant first.
- R9: After reset, status_o is 00h, its bits 7 to 2 are always 0, and sleep_o, op_fire_o and rd_start_o are 0.
- R10: On acceptance, op_fire_o pulses for one cycle. op_kind_o is 1 for status write, 2 for 02h and A2h, 3 for 42h, 4 for E5h, 5 for 20h, 6 for D8h and 7 for C7h. op_arg_o is the status byte for status write, 0 for full erase, and the 24-bit address otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| mosi | input | 1 | Serial data in, most significant bit first |
| status_o | output | 8 | Bit 0 busy, bit 1 write-enable latch, rest 0 |
| sleep_o | output | 1 | Sleep state active |
| op_fire_o | output | 1 | One-cycle pulse for an accepted write-class instruction |
| op_kind_o | output | 3 | Kind code of the accepted instruction |
| op_arg_o | output | 24 | Address or status byte of the accepted instruction |
| rd_start_o | output | 1 | One-cycle pulse when a read address is complete |
| rd_addr_o | output | 24 | Start address of the read |

## Verification
The hardest situation to reach is an instruction that arrives while a cycle is still running. It must be dropped without touching the latch, and the latch must then clear exactly when the busy flag falls. The bench sets the busy durations shorter than the defaults but longer than a whole serial frame, so that a latch-clear frame and a complete read frame both fit inside one erase window. Frames cut short by a few bits, and frames with one byte too many, are mixed in to probe the byte-boundary rule. A behavioural model follows every clock.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_RD        = 8'h03;
  localparam logic [7:0] OP_RD_FAST   = 8'h0B;
  localparam logic [7:0] OP_PROG      = 8'h02;
  localparam logic [7:0] OP_PROG_X2   = 8'hA2;
  localparam logic [7:0] OP_PROG_OTP  = 8'h42;
  localparam logic [7:0] OP_LOCK_WR   = 8'hE5;
  localparam logic [7:0] OP_ERASE_4K  = 8'h20;
  localparam logic [7:0] OP_ERASE_64K = 8'hD8;
  localparam logic [7:0] OP_ERASE_ALL = 8'hC7;
  localparam logic [7:0] OP_SLEEP     = 8'hB9;
  localparam logic [7:0] OP_WAKE      = 8'hAB;

  localparam int NB_W = 8;  // saturating byte counter width
  localparam int AD_W = 24;

  typedef enum logic [2:0] {
    K_NONE = 3'd0, K_STAT = 3'd1, K_PROG = 3'd2, K_OTP = 3'd3,
    K_LOCK = 3'd4, K_SUB  = 3'd5, K_SEC  = 3'd6, K_BULK = 3'd7
  } wkind_e;

  typedef struct packed {
    logic [7:0]      opc;
    logic [NB_W-1:0] nbytes;
    logic [2:0]      phase;
    logic [AD_W-1:0] addr;
    logic [7:0]      tail;
  } frame_t;

  function automatic wkind_e kind_of(input logic [7:0] opc);
    case (opc)
      OP_STAT_WR:              return K_STAT;
      OP_PROG, OP_PROG_X2:     return K_PROG;
      OP_PROG_OTP:             return K_OTP;
      OP_LOCK_WR:              return K_LOCK;
      OP_ERASE_4K:             return K_SUB;
      OP_ERASE_64K:            return K_SEC;
      OP_ERASE_ALL:            return K_BULK;
      default:                 return K_NONE;
    endcase
  endfunction

  function automatic logic len_ok(input wkind_e k, input logic [NB_W-1:0] n);
    case (k)
      K_STAT:         return n == NB_W'(2);
      K_PROG, K_OTP:  return n >= NB_W'(5);
      K_LOCK:         return n == NB_W'(5);
      K_SUB, K_SEC:   return n == NB_W'(4);
      K_BULK:         return n == NB_W'(1);
      default:        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sfc_rx.sv
`timescale 1ns/1ps
module sfc_rx
  import sfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            mosi,
  output logic            cs_rise,
  output logic            addr_evt,
  output logic [AD_W-1:0] addr_next,
  output frame_t          frame
);
  logic            cs_q, sclk_q;
  logic [AD_W-1:0] sh;
  logic [7:0]      opc_q;
  logic [NB_W-1:0] nb_q;
  logic [2:0]      ph_q;
  logic [AD_W-1:0] adr_q;
  logic            sclk_rise;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign cs_rise   = cs_n & ~cs_q;
  assign addr_next = {sh[AD_W-2:0], mosi};
  assign addr_evt  = sclk_rise && (nb_q == NB_W'(3)) && (ph_q == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      sh     <= '0;
      opc_q  <= '0;
      nb_q   <= '0;
      ph_q   <= '0;
      adr_q  <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n) begin
        nb_q <= '0;
        ph_q <= '0;
      end else if (sclk_rise) begin
        sh   <= addr_next;
        ph_q <= ph_q + 3'd1;
        if (ph_q == 3'd7) begin
          if (nb_q != {NB_W{1'b1}}) nb_q <= nb_q + NB_W'(1);
          if (nb_q == '0) opc_q <= addr_next[7:0];
        end
        if (addr_evt) adr_q <= addr_next;
      end
    end
  end

  assign frame = '{opc: opc_q, nbytes: nb_q, phase: ph_q, addr: adr_q, tail: sh[7:0]};

  // R2: a deselected device holds no partial frame
  a_r2_clear_on_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (nb_q == '0 && ph_q == '0));
endmodule

// File: rtl/sfc_busy_timer.sv
`timescale 1ns/1ps
module sfc_busy_timer
  import sfc_pkg::*;
#(
  parameter int T_STAT = 2000,
  parameter int T_PROG = 500,
  parameter int T_SUB  = 4000,
  parameter int T_SEC  = 8000,
  parameter int T_BULK = 16000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  wkind_e kind,
  output logic   busy,
  output logic   done
);
  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = maxi(maxi(maxi(T_STAT, T_PROG), maxi(T_SUB, T_SEC)), T_BULK);
  localparam int CW    = $clog2(T_MAX + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] dur(input wkind_e k);
    case (k)
      K_STAT:                 return CW'(T_STAT);
      K_PROG, K_OTP, K_LOCK:  return CW'(T_PROG);
      K_SUB:                  return CW'(T_SUB);
      K_SEC:                  return CW'(T_SEC);
      K_BULK:                 return CW'(T_BULK);
      default:                return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= dur(kind);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R4: a running cycle counts down one per clock
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt == $past(cnt) - CW'(1)));
  // R3: no new cycle starts on top of a running one
  a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/sfc_ctrl.sv
`timescale 1ns/1ps
module sfc_ctrl
  import sfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_rise,
  input  logic            addr_evt,
  input  logic [AD_W-1:0] addr_next,
  input  frame_t          frame,
  input  logic            busy,
  input  logic            done,
  output logic            start,
  output wkind_e          start_kind,
  output logic            wr_latch,
  output logic            sleep,
  output logic            fire,
  output logic [2:0]      fire_kind,
  output logic [AD_W-1:0] fire_arg,
  output logic            rd_go,
  output logic [AD_W-1:0] rd_addr
);
  wkind_e k;
  logic   at_edge, single;

  always_comb begin
    k          = kind_of(frame.opc);
    single     = (frame.nbytes == NB_W'(1));
    at_edge    = cs_rise && (frame.phase == 3'd0) && !busy;
    start      = at_edge && !sleep && wr_latch && (k != K_NONE) && len_ok(k, frame.nbytes);
    start_kind = k;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_latch  <= 1'b0;
      sleep     <= 1'b0;
      fire      <= 1'b0;
      fire_kind <= '0;
      fire_arg  <= '0;
      rd_go     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      fire  <= start;
      rd_go <= 1'b0;
      if (start) begin
        fire_kind <= k;
        if (k == K_STAT)      fire_arg <= {{(AD_W-8){1'b0}}, frame.tail};
        else if (k == K_BULK) fire_arg <= '0;
        else                  fire_arg <= frame.addr;
      end
      if (done) wr_latch <= 1'b0;
      if (at_edge && single) begin
        if (sleep) begin
          if (frame.opc == OP_WAKE) sleep <= 1'b0;
        end else begin
          case (frame.opc)
            OP_WR_EN:  wr_latch <= 1'b1;
            OP_WR_DIS: wr_latch <= 1'b0;
            OP_SLEEP:  sleep    <= 1'b1;
            default:   ;
          endcase
        end
      end
      if (addr_evt && !busy && !sleep &&
          (frame.opc == OP_RD || frame.opc == OP_RD_FAST)) begin
        rd_go   <= 1'b1;
        rd_addr <= addr_next;
      end
    end
  end

  // R7: nothing is accepted out of sleep
  a_r7_sleep_no_fire: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !fire);
  // R3: reads are not started while busy
  a_r3_busy_no_read: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd_go);
endmodule

// File: rtl/sflash_cmd_ctrl.sv
`timescale 1ns/1ps
module sflash_cmd_ctrl
  import sfc_pkg::*;
#(
  parameter int T_STAT = 2000,
  parameter int T_PROG = 500,
  parameter int T_SUB  = 4000,
  parameter int T_SEC  = 8000,
  parameter int T_BULK = 16000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic [7:0]  status_o,
  output logic        sleep_o,
  output logic        op_fire_o,
  output logic [2:0]  op_kind_o,
  output logic [23:0] op_arg_o,
  output logic        rd_start_o,
  output logic [23:0] rd_addr_o
);
  logic            cs_rise, addr_evt, start, busy, done, wr_latch;
  logic [AD_W-1:0] addr_next;
  frame_t          frame;
  wkind_e          start_kind;

  sfc_rx u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .cs_rise(cs_rise), .addr_evt(addr_evt), .addr_next(addr_next), .frame(frame)
  );

  sfc_busy_timer #(
    .T_STAT(T_STAT), .T_PROG(T_PROG), .T_SUB(T_SUB), .T_SEC(T_SEC), .T_BULK(T_BULK)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start), .kind(start_kind), .busy(busy), .done(done)
  );

  sfc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .addr_evt(addr_evt), .addr_next(addr_next),
    .frame(frame), .busy(busy), .done(done), .start(start), .start_kind(start_kind),
    .wr_latch(wr_latch), .sleep(sleep_o), .fire(op_fire_o), .fire_kind(op_kind_o),
    .fire_arg(op_arg_o), .rd_go(rd_start_o), .rd_addr(rd_addr_o)
  );

  assign status_o = {6'b0, wr_latch, busy};

  // R5: the latch is gone when a cycle ends
  a_r5_latch_drops_with_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wr_latch);
  // R4: an accepted instruction is visible as busy at once
  a_r4_busy_on_fire: assert property (@(posedge clk) disable iff (rst)
    op_fire_o |-> busy);
  // R1: acceptance needs the latch set beforehand
  a_r1_latch_before_fire: assert property (@(posedge clk) disable iff (rst)
    op_fire_o |-> $past(wr_latch));
endmodule

// File: tb/test_sflash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_sflash_cmd_ctrl;
  localparam int T_STAT = 120, T_PROG = 150, T_SUB = 200, T_SEC = 240, T_BULK = 300;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [7:0]  status_o;
  logic        sleep_o, op_fire_o, rd_start_o;
  logic [2:0]  op_kind_o;
  logic [23:0] op_arg_o, rd_addr_o;

  int checks = 0, fails = 0, fires = 0, rds = 0;
  int last_kind = 0;
  logic [23:0] last_arg = '0, last_rd = '0;

  always #5 clk = ~clk;

  sflash_cmd_ctrl #(.T_STAT(T_STAT), .T_PROG(T_PROG), .T_SUB(T_SUB), .T_SEC(T_SEC), .T_BULK(T_BULK))
  i_sflash_cmd_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .status_o(status_o),
    .sleep_o(sleep_o), .op_fire_o(op_fire_o), .op_kind_o(op_kind_o), .op_arg_o(op_arg_o),
    .rd_start_o(rd_start_o), .rd_addr_o(rd_addr_o)
  );

  // ---------------- behavioural reference model ----------------
  int          m_bits = 0, m_busy = 0, m_kind = 0;
  logic [7:0]  m_bytes[$];
  logic [7:0]  m_cur = '0;
  bit          m_wel = 0, m_dp = 0, m_fire = 0, m_rd = 0, m_csq = 1, m_sclkq = 0;
  logic [23:0] m_arg = '0, m_rdaddr = '0;

  function automatic int kind_m(input logic [7:0] o);
    case (o)
      8'h01: return 1;  8'h02, 8'hA2: return 2;  8'h42: return 3;  8'hE5: return 4;
      8'h20: return 5;  8'hD8: return 6;  8'hC7: return 7;  default: return 0;
    endcase
  endfunction
  function automatic bit len_m(input int k, input int n);
    case (k)
      1: return n == 2;  2, 3: return n >= 5;  4: return n == 5;
      5, 6: return n == 4;  7: return n == 1;  default: return 0;
    endcase
  endfunction
  function automatic int dur_m(input int k);
    case (k)
      1: return T_STAT;  2, 3, 4: return T_PROG;  5: return T_SUB;
      6: return T_SEC;  default: return T_BULK;
    endcase
  endfunction

  always @(posedge clk) begin
    bit busy_now, go;
    int nb, k;
    logic [7:0] opc;
    if (rst) begin
      m_bits = 0; m_busy = 0; m_wel = 0; m_dp = 0; m_fire = 0; m_rd = 0;
      m_kind = 0; m_arg = '0; m_rdaddr = '0; m_csq = 1; m_sclkq = 0;
      m_bytes.delete();
    end else begin
      busy_now = (m_busy > 0); m_fire = 0; m_rd = 0; go = 0; k = 0;
      if (cs_n && !m_csq && (m_bits % 8 == 0) && m_bits >= 8 && !busy_now) begin
        nb = m_bits / 8; opc = m_bytes[0];
        if (m_dp) begin
          if (nb == 1 && opc == 8'hAB) m_dp = 0;
        end else begin
          k = kind_m(opc);
          if (k != 0 && m_wel && len_m(k, nb)) begin
            go = 1; m_fire = 1; m_kind = k;
            if (k == 1)      m_arg = {16'h0, m_bytes[1]};
            else if (k == 7) m_arg = '0;
            else             m_arg = {m_bytes[1], m_bytes[2], m_bytes[3]};
          end
          if (nb == 1 && opc == 8'h06) m_wel = 1;
          if (nb == 1 && opc == 8'h04) m_wel = 0;
          if (nb == 1 && opc == 8'hB9) m_dp = 1;
        end
      end
      if (go) m_busy = dur_m(k);
      else if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) m_wel = 0;
      end
      if (cs_n) begin
        m_bits = 0; m_bytes.delete();
      end else if (sclk && !m_sclkq) begin
        m_cur = {m_cur[6:0], mosi}; m_bits++;
        if (m_bits % 8 == 0) m_bytes.push_back(m_cur);
        if (m_bits == 32 && !busy_now && !m_dp && (m_bytes[0] == 8'h03 || m_bytes[0] == 8'h0B)) begin
          m_rd = 1; m_rdaddr = {m_bytes[1], m_bytes[2], m_bytes[3]};
        end
      end
      m_csq = cs_n; m_sclkq = sclk;
    end
  end

  // ---------------- per-cycle comparison and monitor ----------------
  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      cmp("R4 busy bit", 32'(status_o[0]), 32'(m_busy > 0));
      cmp("R6 latch bit", 32'(status_o[1]), 32'(m_wel));
      cmp("R9 spare status bits", 32'(status_o[7:2]), 32'h0);
      cmp("R7 sleep", 32'(sleep_o), 32'(m_dp));
      cmp("R2 fire pulse", 32'(op_fire_o), 32'(m_fire));
      if (m_fire) begin
        cmp("R10 kind", 32'(op_kind_o), 32'(m_kind));
        cmp("R10 arg", 32'(op_arg_o), 32'(m_arg));
      end
      cmp("R8 read pulse", 32'(rd_start_o), 32'(m_rd));
      if (m_rd) cmp("R8 read addr", 32'(rd_addr_o), 32'(m_rdaddr));
      if (op_fire_o) begin fires++; last_kind = int'(op_kind_o); last_arg = op_arg_o; end
      if (rd_start_o) begin rds++; last_rd = rd_addr_o; end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i]; sclk = 1'b0; tick(2);
      sclk = 1'b1; tick(2);
    end
  endtask

  // n bytes, most significant byte of d[8n-1:0] first, then extra partial bits
  task automatic xfer(input int n, input logic [47:0] d, input int extra);
    cs_n = 1'b0; tick(2);
    for (int i = 0; i < n; i++) put_bits(d[8*(n-1-i) +: 8], 8);
    if (extra > 0) put_bits(8'hA5, extra);
    sclk = 1'b0; tick(2);
    cs_n = 1'b1; tick(3);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (status_o[0]) tick(1);
    tick(1);
  endtask

  initial begin
    int n;
    tick(5); rst = 1'b0; tick(2);
    chk("R9 reset status", 32'(status_o), 32'h00);
    chk("R9 reset sleep", 32'(sleep_o), 32'h0);

    xfer(6, 48'h02_00_10_00_AA_BB, 0);
    chk("R1 program without latch", 32'(fires), 0);
    chk("R1 no busy", 32'(status_o), 32'h00);

    xfer(1, 48'h06, 0);
    chk("R6 latch set", 32'(status_o), 32'h02);
    xfer(1, 48'h04, 0);
    chk("R6 latch clear", 32'(status_o), 32'h00);
    xfer(1, 48'h06, 0);

    xfer(3, 48'h20_01_20, 6);
    chk("R2 partial frame ignored", 32'(fires), 0);
    xfer(2, 48'h04_00, 0);
    chk("R2 long latch-clear ignored", 32'(status_o), 32'h02);

    xfer(4, 48'h20_01_23_45, 0);
    chk("R4 busy after erase", 32'(status_o), 32'h03);
    chk("R10 erase kind", 32'(last_kind), 5);
    chk("R10 erase addr", 32'(last_arg), 32'h012345);
    xfer(1, 48'h04, 0);
    chk("R3 latch clear ignored while busy", 32'(status_o), 32'h03);
    xfer(4, 48'h03_00_00_10, 0);
    chk("R3 read ignored while busy", 32'(rds), 0);
    wait_idle();
    chk("R5 latch cleared at end", 32'(status_o), 32'h00);

    xfer(1, 48'h06, 0);
    xfer(4, 48'hD8_05_00_00, 0);
    n = 0;
    while (status_o[0]) begin n++; tick(1); end
    chk("R4 sector erase duration", 32'(n), 32'(T_SEC - 2));

    xfer(4, 48'h03_12_34_56, 0);
    chk("R8 read pulse", 32'(rds), 1);
    chk("R8 read addr", 32'(last_rd), 32'h123456);
    xfer(5, 48'h0B_00_00_FF_00, 0);
    chk("R8 fast read addr", 32'(last_rd), 32'h0000FF);

    xfer(1, 48'hB9, 0);
    chk("R7 sleep entered", 32'(sleep_o), 1);
    xfer(1, 48'h06, 0);
    chk("R7 latch set ignored in sleep", 32'(status_o), 32'h00);
    xfer(4, 48'h03_00_00_01, 0);
    chk("R7 read ignored in sleep", 32'(rds), 2);
    xfer(1, 48'hAB, 0);
    chk("R7 sleep left", 32'(sleep_o), 0);

    xfer(1, 48'h06, 0);
    xfer(2, 48'h01_3C, 0);
    chk("R10 status write kind", 32'(last_kind), 1);
    chk("R10 status write arg", 32'(last_arg), 32'h3C);
    wait_idle();

    xfer(1, 48'h06, 0);
    n = fires;
    xfer(5, 48'h02_00_01_00_11, 3);
    chk("R2 program cut mid-byte", 32'(fires), 32'(n));
    xfer(6, 48'h02_00_01_00_11_22, 0);
    chk("R10 program kind", 32'(last_kind), 2);
    chk("R10 program addr", 32'(last_arg), 32'h000100);
    wait_idle();

    xfer(1, 48'h06, 0);
    xfer(1, 48'hC7, 0);
    chk("R10 full erase kind", 32'(last_kind), 7);
    chk("R10 full erase arg", 32'(last_arg), 32'h0);
    wait_idle();

    xfer(1, 48'h06, 0);
    xfer(5, 48'hE5_01_00_00_01, 0);
    chk("R10 lock kind", 32'(last_kind), 4);
    wait_idle();
    xfer(1, 48'h06, 0);
    xfer(5, 48'h42_00_00_05_00, 0);
    chk("R10 otp kind", 32'(last_kind), 3);
    wait_idle();
    xfer(1, 48'h06, 0);
    xfer(5, 48'hA2_00_02_00_77, 0);
    chk("R10 dual program kind", 32'(last_kind), 2);
    wait_idle();
    chk("R5 latch cleared after program", 32'(status_o), 32'h00);

    tick(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule